// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction History

This block predicts the direction and destination of branches for an in-order pipeline. When a branch reaches the decode stage, its fetch address is searched across every entry of the buffer in the same cycle. The block answers with a hit flag, a taken or not-taken guess and the next fetch address. That address is either the recorded destination or the sequential address (the fetch address plus 4).

When the execute stage resolves a branch, it reports the branch address, the real direction, the real destination and whether the earlier guess was wrong. With that report the block does four things:

- It trains the two-bit saturating history of a matching entry.
- It refreshes the stored destination when a taken branch goes somewhere new.
- It records taken branches that are not yet held.
- It raises a flush request together with the address fetch must restart from.

Branches that miss in the buffer are always guessed not-taken, unconditional jumps included, until they have been seen taken once. Free slots are filled lowest index first. Once every slot is in use, slots are reused in rotating order.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous reset clears every entry's valid bit and returns the rotating replacement pointer to slot 0, so every lookup after reset misses.
- R2: Any slot may hold any branch, and at most one valid slot ever matches a given address.
- R3: `pred_hit` is 1 when `lk_valid` is 1 and a valid slot's stored tag equals `lk_pc[31:2]`; it is 0 otherwise.
- R4: On a miss, `pred_taken` is 0 and `pred_target` is `lk_pc + 4`, whatever kind of branch is being looked up.
- R5: A resolution with `upd_taken`=1 for an address that is not held records the address and `upd_target` in a slot, with history 2'b11. A not-taken resolution of an address that is not held records nothing.
- R6: On a hit, `pred_taken` equals bit 1 of the slot's history. `pred_target` is the stored destination when `pred_taken` is 1, and `lk_pc + 4` otherwise.
- R7: The history encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken. Each resolution of a held branch adds 1 when taken and subtracts 1 when not taken, and saturates at 00 and 11.
- R8: A taken resolution of a held branch replaces its stored destination with `upd_target`.
- R9: `flush_req` is 1 in the same cycle as `upd_valid`=1 with `upd_mispredict`=1, and 0 otherwise. `flush_pc` is `upd_target` when `upd_taken` is 1, and `upd_pc + 4` otherwise.
- R10: While some slot is free, a new branch goes into the free slot with the lowest index.
- R11: When all slots are in use, a new branch overwrites the slot named by the replacement pointer. The pointer then advances by one and wraps from the last slot to slot 0. It moves on no other event.
- R12: The lookup reads the state as it stood before any resolution in the same cycle, including a resolution of the same address. The change is seen from the next cycle on.
- R13: Address bits [1:0] play no part in matching or allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | A branch is at decode and is being looked up |
| lk_pc | input | 32 | Fetch address of the branch at decode |
| pred_hit | output | 1 | The looked-up address is held in the buffer |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_target | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | 32 | Actual destination of the resolved branch |
| upd_mispredict | input | 1 | The earlier guess for this branch was wrong |
| flush_req | output | 1 | The pipeline must discard younger work and refetch |
| flush_pc | output | 32 | Address from which fetch restarts |

## Verification
The uniqueness and allocation properties rely on the buffer being trained only through its own allocation path. No address is ever recorded twice, because a resolution that already matches a slot never allocates. The bench keeps to this by reporting each branch exactly as a pipeline would, and it never drives a resolution with X on its address or direction. The flush properties take `upd_mispredict` to be an input that is trusted as given, so the bench drives it freely, both in agreement with and against the block's own guess.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  // Saturating step of the direction history.
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t n;
    unique case (c)
      CTR_SNT: n = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: n = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  n = taken ? CTR_ST  : CTR_WNT;
      default: n = taken ? CTR_ST  : CTR_WT;
    endcase
    return n;
  endfunction

  function automatic logic ctr_is_taken(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int N  = 256,
  parameter int TW = 30,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][TW-1:0] tags,
  input  logic [TW-1:0]        key,
  output logic [N-1:0]         hit_vec,
  output logic                 hit,
  output logic [IW-1:0]        idx
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/btb_alloc.sv
module btb_alloc #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  valid,
  input  logic [IW-1:0] rr_ptr,
  output logic          full,
  output logic [IW-1:0] victim
);

  logic [IW-1:0] low_free;

  always_comb begin
    low_free = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) low_free = IW'(i);
    end
  end

  assign full   = &valid;
  assign victim = full ? rr_ptr : low_free;

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_pc,
  output logic          pred_hit,
  output logic          pred_taken,
  output logic [AW-1:0] pred_target,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_taken,
  input  logic [AW-1:0] upd_target,
  input  logic          upd_mispredict,
  output logic          flush_req,
  output logic [AW-1:0] flush_pc
);

  localparam int N  = ENTRIES;
  localparam int TW = AW - 2;
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [N-1:0]         valid_q;
  logic [N-1:0][TW-1:0] tag_q;
  logic [N-1:0][AW-1:0] tgt_q;
  ctr_t                 ctr_q [N];
  logic [IW-1:0]        rr_ptr;

  // Lookup side
  logic [N-1:0]  lk_hit_vec;
  logic          lk_hit;
  logic [IW-1:0] lk_idx;
  ctr_t          lk_ctr;

  btb_match #(.N(N), .TW(TW), .IW(IW)) u_lk_match (
    .valid(valid_q), .tags(tag_q), .key(lk_pc[AW-1:2]),
    .hit_vec(lk_hit_vec), .hit(lk_hit), .idx(lk_idx)
  );

  assign lk_ctr      = ctr_q[lk_idx];
  assign pred_hit    = lk_valid && lk_hit;
  assign pred_taken  = pred_hit && ctr_is_taken(lk_ctr);
  assign pred_target = pred_taken ? tgt_q[lk_idx] : lk_pc + AW'(4);

  // Update side
  logic [N-1:0]  upd_hit_vec;
  logic          upd_hit;
  logic [IW-1:0] upd_idx;
  logic          buf_full;
  logic [IW-1:0] victim;
  logic          train_fire;
  logic          tgt_change;
  logic          alloc_fire;
  logic          replace_fire;

  btb_match #(.N(N), .TW(TW), .IW(IW)) u_upd_match (
    .valid(valid_q), .tags(tag_q), .key(upd_pc[AW-1:2]),
    .hit_vec(upd_hit_vec), .hit(upd_hit), .idx(upd_idx)
  );

  btb_alloc #(.N(N), .IW(IW)) u_alloc (
    .valid(valid_q), .rr_ptr(rr_ptr), .full(buf_full), .victim(victim)
  );

  assign train_fire   = upd_valid && upd_hit;
  assign tgt_change   = train_fire && upd_taken && (tgt_q[upd_idx] != upd_target);
  assign alloc_fire   = upd_valid && upd_taken && !upd_hit;
  assign replace_fire = alloc_fire && buf_full;

  assign flush_req = upd_valid && upd_mispredict;
  assign flush_pc  = upd_taken ? upd_target : upd_pc + AW'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      rr_ptr  <= '0;
    end else begin
      if (alloc_fire) valid_q[victim] <= 1'b1;
      if (replace_fire) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (train_fire) ctr_q[upd_idx] <= ctr_step(ctr_q[upd_idx], upd_taken);
    if (tgt_change) tgt_q[upd_idx] <= upd_target;
    if (alloc_fire) begin
      tag_q[victim] <= upd_pc[AW-1:2];
      tgt_q[victim] <= upd_target;
      ctr_q[victim] <= CTR_ST;
    end
  end

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int N  = 256,
  parameter int AW = 32,
  parameter int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  valid_q,
  input logic [IW-1:0] rr_ptr,
  input logic [N-1:0]  lk_hit_vec,
  input logic          lk_valid,
  input logic [AW-1:0] lk_pc,
  input logic          pred_hit,
  input logic          pred_taken,
  input logic [AW-1:0] pred_target,
  input logic          upd_taken,
  input logic [AW-1:0] upd_pc,
  input logic          flush_req,
  input logic [AW-1:0] flush_pc,
  input logic          alloc_fire,
  input logic          buf_full,
  input logic          replace_fire
);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_q == '0 && rr_ptr == '0));

  p_onehot_match_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_vec));

  p_miss_not_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !pred_hit) |-> (!pred_taken && pred_target == lk_pc + AW'(4)));

  p_alloc_grows_r5: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && !buf_full) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

  p_flush_seq_r9: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !upd_taken) |-> (flush_pc == upd_pc + AW'(4)));

  p_ptr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !replace_fire |=> $stable(rr_ptr));

  p_ptr_moves_r11: assert property (@(posedge clk) disable iff (rst)
    replace_fire |=> (rr_ptr != $past(rr_ptr) && (&valid_q)));

endmodule

bind btb_predictor btb_checker #(.N(N), .AW(AW), .IW(IW)) u_chk (.*);

// File: tb/test_btb_predictor.sv
module test_btb_predictor;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic        upd_mispredict = 1'b0;
  logic        flush_req;
  logic [31:0] flush_pc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  btb_predictor #(.ENTRIES(N), .AW(32)) i_btb_predictor (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_mispredict(upd_mispredict),
    .flush_req(flush_req), .flush_pc(flush_pc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; upd_valid = 1'b0; lk_valid = 1'b0; upd_mispredict = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One resolution, committed at the next rising edge; returns at the following falling edge.
  task automatic resolve(input logic [31:0] pc, input logic taken, input logic [31:0] tgt);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = taken; upd_target = tgt; upd_mispredict = 1'b0;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // Look up and compare the combinational answer.
  task automatic expect_pred(input string req, input logic [31:0] pc, input logic hit,
                             input logic taken, input logic [31:0] tgt);
    lk_valid = 1'b1; lk_pc = pc;
    #1;
    chk(req, "hit", 32'(pred_hit), 32'(hit));
    chk(req, "taken", 32'(pred_taken), 32'(taken));
    chk(req, "target", pred_target, tgt);
    lk_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_pred("R1", 32'h0000_0040, 1'b0, 1'b0, 32'h0000_0044);
    expect_pred("R1", 32'h8000_0000, 1'b0, 1'b0, 32'h8000_0004);
  endtask

  task automatic t_miss_and_alloc();
    do_reset();
    // R4: a jump never seen is guessed not-taken
    expect_pred("R4", 32'h0000_1000, 1'b0, 1'b0, 32'h0000_1004);
    // R5: a not-taken resolution of an unknown branch records nothing
    resolve(32'h0000_1000, 1'b0, 32'h0000_2000);
    expect_pred("R5", 32'h0000_1000, 1'b0, 1'b0, 32'h0000_1004);
    // R5/R3/R6: a taken resolution records it as strongly taken
    resolve(32'h0000_1000, 1'b1, 32'h0000_2000);
    expect_pred("R6", 32'h0000_1000, 1'b1, 1'b1, 32'h0000_2000);
    // R13: low address bits do not take part in the match
    expect_pred("R13", 32'h0000_1003, 1'b1, 1'b1, 32'h0000_2000);
    expect_pred("R3", 32'h0000_1004, 1'b0, 1'b0, 32'h0000_1008);
  endtask

  task automatic t_counter();
    logic [31:0] a;
    a = 32'h0000_3000;
    do_reset();
    resolve(a, 1'b1, 32'h0000_5000);           // 11
    resolve(a, 1'b1, 32'h0000_5000);           // stays 11
    resolve(a, 1'b0, 32'h0000_5000);           // 10
    expect_pred("R7", a, 1'b1, 1'b1, 32'h0000_5000);
    resolve(a, 1'b0, 32'h0000_5000);           // 01
    expect_pred("R7", a, 1'b1, 1'b0, a + 4);
    resolve(a, 1'b0, 32'h0000_5000);           // 00
    resolve(a, 1'b0, 32'h0000_5000);           // stays 00
    resolve(a, 1'b1, 32'h0000_5000);           // 01
    expect_pred("R7", a, 1'b1, 1'b0, a + 4);
    resolve(a, 1'b1, 32'h0000_6000);           // 10, new target
    expect_pred("R8", a, 1'b1, 1'b1, 32'h0000_6000);
  endtask

  task automatic t_same_cycle();
    logic [31:0] a;
    a = 32'h0000_7000;
    do_reset();
    resolve(a, 1'b1, 32'h0000_7800);           // 11
    resolve(a, 1'b0, 32'h0000_7800);           // 10
    // resolution to 01 and lookup in the same cycle
    upd_valid = 1'b1; upd_pc = a; upd_taken = 1'b0; upd_target = 32'h0000_7800;
    lk_valid = 1'b1; lk_pc = a;
    #1;
    chk("R12", "pre-update taken", 32'(pred_taken), 32'd1);
    chk("R12", "pre-update target", pred_target, 32'h0000_7800);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    chk("R12", "post-update taken", 32'(pred_taken), 32'd0);
    lk_valid = 1'b0;
  endtask

  task automatic t_flush();
    do_reset();
    upd_valid = 1'b1; upd_pc = 32'h0000_9000; upd_taken = 1'b1;
    upd_target = 32'h0000_A000; upd_mispredict = 1'b1;
    #1;
    chk("R9", "flush on taken miss", 32'(flush_req), 32'd1);
    chk("R9", "flush pc taken", flush_pc, 32'h0000_A000);
    upd_taken = 1'b0;
    #1;
    chk("R9", "flush pc sequential", flush_pc, 32'h0000_9004);
    upd_mispredict = 1'b0;
    #1;
    chk("R9", "no flush when correct", 32'(flush_req), 32'd0);
    upd_mispredict = 1'b1; upd_valid = 1'b0;
    #1;
    chk("R9", "no flush without report", 32'(flush_req), 32'd0);
    upd_mispredict = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_fill_replace();
    do_reset();
    for (int i = 0; i < 4; i++) resolve(32'h0000_1000 + 32'(i * 16), 1'b1, 32'h0000_8000 + 32'(i * 16));
    for (int i = 0; i < 4; i++)
      expect_pred("R2", 32'h0000_1000 + 32'(i * 16), 1'b1, 1'b1, 32'h0000_8000 + 32'(i * 16));
    // full: first replacement takes slot 0, which was filled first (R10)
    resolve(32'h0000_1040, 1'b1, 32'h0000_8040);
    expect_pred("R10", 32'h0000_1000, 1'b0, 1'b0, 32'h0000_1004);
    expect_pred("R11", 32'h0000_1040, 1'b1, 1'b1, 32'h0000_8040);
    expect_pred("R11", 32'h0000_1010, 1'b1, 1'b1, 32'h0000_8010);
    resolve(32'h0000_1050, 1'b1, 32'h0000_8050);   // slot 1
    expect_pred("R11", 32'h0000_1010, 1'b0, 1'b0, 32'h0000_1014);
    resolve(32'h0000_1060, 1'b1, 32'h0000_8060);   // slot 2
    resolve(32'h0000_1070, 1'b1, 32'h0000_8070);   // slot 3
    resolve(32'h0000_1080, 1'b1, 32'h0000_8080);   // wraps to slot 0
    expect_pred("R11", 32'h0000_1040, 1'b0, 1'b0, 32'h0000_1044);
    expect_pred("R11", 32'h0000_1050, 1'b1, 1'b1, 32'h0000_8050);
    expect_pred("R11", 32'h0000_1080, 1'b1, 1'b1, 32'h0000_8080);
    // training a held branch does not move the pointer: next new one takes slot 1
    resolve(32'h0000_1050, 1'b0, 32'h0000_8050);
    resolve(32'h0000_1090, 1'b1, 32'h0000_8090);
    expect_pred("R11", 32'h0000_1050, 1'b0, 1'b0, 32'h0000_1054);
    expect_pred("R11", 32'h0000_1060, 1'b1, 1'b1, 32'h0000_8060);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_miss_and_alloc();
    t_counter();
    t_same_cycle();
    t_flush();
    t_fill_replace();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule